// File: doc/BRIEF.md
# Ballot Entry Unit with Repeat-Vote Lockout

This block takes ballots from a fixed roll of registered voters. Each voter has an input line pair: a one-cycle strobe that marks a ballot as present, and a code that names the chosen candidate. The block counts the first ballot from each voter into a per-candidate tally. On the same edge it sets a sticky "has voted" flag for that voter. Any later ballot from a voter whose flag is set is dropped without effect.

A registered status output per voter reports "voted" one cycle after the flag is set. Voters may appear in any order and in consecutive cycles. Several voters may also strobe in the same cycle. They are handled in ascending voter index, so one candidate's tally can rise by more than one on a single edge. A synchronous clear returns every flag, status bit and tally to zero, and no ballot is taken while the clear is high.

Top module: `ballot_lockout`

## Requirements
- R1: While `clr` is high at a rising edge, every bit of `voted_flag`, `voted_status` and `tally` reads 0 after that edge.
- R2: A strobe on voter i with `clr` low and that voter's flag at 0 sets `voted_flag[i]` to 1 on that same edge.
- R3: An accepted ballot with code k raises the tally of candidate k by one on that edge. Candidate k's tally sits at `tally[k*TALLY_W +: TALLY_W]`, and codes 0, 1, 2 and 3 map to the first, second, third and fourth candidate.
- R4: A strobe from a voter whose flag is already 1 changes no tally and no flag.
- R5: `voted_status[i]` equals the value `voted_flag[i]` held one clock earlier.
- R6: Voters are accepted in any roll order, and a different voter may be accepted in the cycle right after another voter's ballot.
- R7: When several voters strobe in one cycle, each eligible ballot is counted. A candidate's tally rises by the number of eligible voters that chose it.
- R8: A strobe that arrives while `clr` is high is not counted and sets no flag.
- R9: The sum of all tallies always equals the number of set flags, and no tally exceeds NUM_VOTERS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous active-high clear |
| ballot_stb | input | NUM_VOTERS | One-cycle ballot strobe per voter |
| ballot_sel | input | NUM_VOTERS*SEL_W | Candidate code per voter; voter i at bits i*SEL_W +: SEL_W |
| voted_flag | output | NUM_VOTERS | Sticky per-voter flag, set on the accepting edge |
| voted_status | output | NUM_VOTERS | Per-voter voted status, one cycle behind the flag |
| tally | output | NUM_CANDS*TALLY_W | Per-candidate ballot counts, candidate k at bits k*TALLY_W +: TALLY_W |

## Verification
The bench builds the block with its default 20 voters and 4 candidates. At that size every voter and every candidate code can be swept fully. A permuted single-voter pass checks order independence and back-to-back acceptance. A full repeat pass then exercises the lockout on every voter. An all-voters-in-one-cycle burst checks multi-count increments, and a strobe-during-clear burst checks clear priority. Each tally is checked up to its maximum of 20.

// File: rtl/ballot_pkg.sv
package ballot_pkg;
  function automatic int unsigned width_for(input int unsigned maxval);
    int unsigned w;
    w = 1;
    while ((1 << w) <= maxval) w++;
    return w;
  endfunction
endpackage

// File: rtl/voter_lock.sv
module voter_lock (
  input  logic clk,
  input  logic clr,
  input  logic stb,
  output logic accept,
  output logic flag
);
  assign accept = stb & ~flag & ~clr;

  always_ff @(posedge clk) begin
    if (clr)         flag <= 1'b0;
    else if (accept) flag <= 1'b1;
  end

  assert_flag_clear_R1: assert property (@(posedge clk) clr |=> !flag);
  assert_flag_set_R2: assert property (@(posedge clk) disable iff (clr) stb |=> flag);
  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (clr) flag |=> flag);
endmodule

// File: rtl/status_stage.sv
module status_stage #(
  parameter int unsigned N = 20
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [N-1:0] flags,
  output logic [N-1:0] status
);
  always_ff @(posedge clk) begin
    if (clr) status <= '0;
    else     status <= flags;
  end

  assert_status_lag_R5: assert property (@(posedge clk) disable iff (clr)
    !$past(clr) |-> status == $past(flags));
  assert_status_cleared_R1: assert property (@(posedge clk) clr |=> status == '0);
endmodule

// File: rtl/tally_accum.sv
module tally_accum #(
  parameter int unsigned N       = 20,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned TALLY_W = 5,
  parameter int unsigned CAND    = 0
) (
  input  logic               clk,
  input  logic               clr,
  input  logic [N-1:0]       accept,
  input  logic [N*SEL_W-1:0] sel,
  output logic [TALLY_W-1:0] count
);
  logic [TALLY_W-1:0] hits;

  always_comb begin
    hits = '0;
    for (int i = 0; i < N; i++) begin
      if (accept[i] && sel[i*SEL_W +: SEL_W] == SEL_W'(CAND))
        hits = hits + TALLY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (clr) count <= '0;
    else     count <= count + hits;
  end

  assert_tally_monotone_R3: assert property (@(posedge clk) disable iff (clr)
    !$past(clr) |-> count >= $past(count));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (clr)
    !$past(clr) |-> count <= TALLY_W'(N));
endmodule

// File: rtl/ballot_lockout.sv
module ballot_lockout
  import ballot_pkg::*;
#(
  parameter int unsigned NUM_VOTERS = 20,
  parameter int unsigned NUM_CANDS  = 4,
  parameter int unsigned SEL_W      = (NUM_CANDS > 1) ? $clog2(NUM_CANDS) : 1,
  parameter int unsigned TALLY_W    = width_for(NUM_VOTERS)
) (
  input  logic                          clk,
  input  logic                          clr,
  input  logic [NUM_VOTERS-1:0]         ballot_stb,
  input  logic [NUM_VOTERS*SEL_W-1:0]   ballot_sel,
  output logic [NUM_VOTERS-1:0]         voted_flag,
  output logic [NUM_VOTERS-1:0]         voted_status,
  output logic [NUM_CANDS*TALLY_W-1:0]  tally
);
  localparam int unsigned SUM_W = TALLY_W + $clog2(NUM_CANDS + 1);

  logic [NUM_VOTERS-1:0] accept;

  for (genvar v = 0; v < NUM_VOTERS; v++) begin : g_voter
    voter_lock u_lock (
      .clk    (clk),
      .clr    (clr),
      .stb    (ballot_stb[v]),
      .accept (accept[v]),
      .flag   (voted_flag[v])
    );
  end

  status_stage #(.N(NUM_VOTERS)) u_status (
    .clk    (clk),
    .clr    (clr),
    .flags  (voted_flag),
    .status (voted_status)
  );

  for (genvar c = 0; c < NUM_CANDS; c++) begin : g_cand
    tally_accum #(
      .N       (NUM_VOTERS),
      .SEL_W   (SEL_W),
      .TALLY_W (TALLY_W),
      .CAND    (c)
    ) u_tally (
      .clk    (clk),
      .clr    (clr),
      .accept (accept),
      .sel    (ballot_sel),
      .count  (tally[c*TALLY_W +: TALLY_W])
    );
  end

  logic [SUM_W-1:0] tally_sum;
  always_comb begin
    tally_sum = '0;
    for (int c = 0; c < NUM_CANDS; c++)
      tally_sum = tally_sum + SUM_W'(tally[c*TALLY_W +: TALLY_W]);
  end

  assert_sum_matches_flags_R9: assert property (@(posedge clk) disable iff (clr)
    !$past(clr) |-> tally_sum == SUM_W'($countones(voted_flag)));
  assert_clear_blocks_R8: assert property (@(posedge clk)
    clr |=> voted_flag == '0 && tally_sum == '0);
endmodule

// File: tb/tb_ballot_lockout.sv
module tb_ballot_lockout;
  localparam int NV = 20;
  localparam int NC = 4;
  localparam int SW = 2;
  localparam int TW = 5;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic clr;
  logic [NV-1:0]    ballot_stb;
  logic [NV*SW-1:0] ballot_sel;
  logic [NV-1:0]    voted_flag, voted_status;
  logic [NC*TW-1:0] tally;

  int checks = 0;
  int errors = 0;
  bit [NV-1:0] exp_flag, exp_stat;
  int exp_tally [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  ballot_lockout dut (
    .clk(clk), .clr(clr), .ballot_stb(ballot_stb), .ballot_sel(ballot_sel),
    .voted_flag(voted_flag), .voted_status(voted_status), .tally(tally)
  );

  task automatic check_all(input string tag);
    checks++;
    if (voted_flag !== exp_flag) begin
      errors++;
      $display("FAIL %s flags act=%h exp=%h", tag, voted_flag, exp_flag);
    end
    checks++;
    if (voted_status !== exp_stat) begin
      errors++;
      $display("FAIL %s status act=%h exp=%h", tag, voted_status, exp_stat);
    end
    for (int c = 0; c < NC; c++) begin
      checks++;
      if (tally[c*TW +: TW] !== TW'(exp_tally[c])) begin
        errors++;
        $display("FAIL %s tally%0d act=%0d exp=%0d", tag, c, tally[c*TW +: TW], exp_tally[c]);
      end
    end
  endtask

  // drive at negedge, model the edge, compare at the following negedge
  task automatic step(input bit c, input bit [NV-1:0] stb, input bit [NV*SW-1:0] sel,
                      input string tag);
    clr = c; ballot_stb = stb; ballot_sel = sel;
    @(posedge clk);
    exp_stat = c ? '0 : exp_flag;
    if (c) begin
      exp_flag = '0;
      for (int k = 0; k < NC; k++) exp_tally[k] = 0;
    end else begin
      for (int v = 0; v < NV; v++)
        if (stb[v] && !exp_flag[v]) begin
          exp_flag[v] = 1'b1;
          exp_tally[sel[v*SW +: SW]]++;
        end
    end
    @(negedge clk);
    ballot_stb = '0;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit [NV*SW-1:0] sel;
    clr = 1'b1; ballot_stb = '0; ballot_sel = '0;
    exp_flag = '0; exp_stat = '0;
    for (int k = 0; k < NC; k++) exp_tally[k] = 0;
    @(negedge clk);
    step(1'b1, '0, '0, "R1 reset");

    // R6 R2 R3 R5: permuted order, one voter per cycle, back-to-back
    for (int i = 0; i < NV; i++) begin
      int v;
      v = (i * 7) % NV;
      sel = '0;
      sel[v*SW +: SW] = SW'(i % NC);
      step(1'b0, NV'(1) << v, sel, "R2 R3 R6 single");
    end
    step(1'b0, '0, '0, "R5 status settle");

    // R4: every voter tries again with a different code
    for (int v = 0; v < NV; v++) begin
      sel = '0;
      sel[v*SW +: SW] = SW'((v + 1) % NC);
      step(1'b0, NV'(1) << v, sel, "R4 repeat");
    end
    step(1'b0, '1, '1, "R4 repeat burst");

    // R8: strobes while clear is high
    step(1'b1, '1, '0, "R8 clear priority");
    step(1'b1, '1, '1, "R8 clear priority");

    // R7: all voters in one cycle
    sel = '0;
    for (int v = 0; v < NV; v++) sel[v*SW +: SW] = SW'((v * 3) % NC);
    step(1'b0, '1, sel, "R7 burst");
    step(1'b0, '0, '0, "R5 R9 after burst");

    // R7: partial burst then rest, all to candidate 3 (tally reaches 20)
    step(1'b1, '0, '0, "R1 reclear");
    step(1'b0, NV'(20'h0_5555), '1, "R7 half burst");
    step(1'b0, '1, '1, "R7 R4 remainder");
    step(1'b0, '0, '0, "R9 full count");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule